// File: doc/BRIEF.md
# Arithmetic status flag generator

This unit evaluates one integer operation per cycle on two operands at a chosen width of 8, 16 or 32 bits. It returns the width-masked result and, from the same operands, the carry, parity, nibble-carry, zero, sign and overflow flags packed into a 16-bit status word. The result and the candidate status word are combinational outputs. A registered copy of the status word is loaded on the rising clock edge whenever the flag write enable is high.

The operation set covers add, add with carry, subtract, subtract with borrow, compare, AND, test, OR, XOR, increment and decrement. Compare and test produce flags only, and they signal through a dedicated output that their result is not to be stored. Increment and decrement keep the carry already held in the registered status word. A down-counting loop can therefore stop on the zero flag without disturbing a carry that is still pending.

Top module: `arith_flag_unit`

## Requirements
- R1: After reset the registered status reads 0x0002. In every status word bit 1 is 1, and bits 3, 5, 8, 9, 10 and 12 to 15 are 0.
- R2: op_sel selects the operation: 0 add a+b, 1 add a+b+carry_in, 2 subtract a-b, 3 subtract a-b-carry_in, 4 compare (a-b), 5 AND, 6 test (a&b), 7 OR, 8 XOR, 9 increment a+1, 10 decrement a-1. The result output carries the value of that operation, including for compare and test.
- R3: size_sel selects the width: 0 is 8 bits, 1 is 16 bits, and 2 or 3 is 32 bits. Operand bits above the width have no effect, and result bits above the width are 0.
- R4: The carry flag (bit 0) is 1 when an add carries out of the top bit of the width, or when a subtract borrows into it.
- R5: The parity flag (bit 2) is 1 when result bits 7:0 hold an even number of ones, at every width.
- R6: The nibble-carry flag (bit 4) is 1 when an add carries out of bit 3, or when a subtract borrows into bit 3.
- R7: The zero flag (bit 6) is 1 exactly when the width-masked result is 0. This includes a decrement that reaches 0.
- R8: The sign flag (bit 7) equals the top result bit of the selected width.
- R9: The overflow flag (bit 11) is 1 when the two's-complement result does not fit in the selected width.
- R10: write_back is 0 for compare, for test and for reserved codes. It is 1 for every other operation.
- R11: AND, test, OR and XOR force the carry, overflow and nibble-carry flags to 0.
- R12: Increment and decrement copy the carry flag from the registered status word. All their other flags are computed from the operation.
- R13: next_flags is combinational. status takes the value of next_flags on a rising edge when flags_we is 1, and holds its value when flags_we is 0.
- R14: For the reserved codes 11 to 15, result is 0 and next_flags equals the current status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | WORD_W | First operand |
| op_b | input | WORD_W | Second operand |
| carry_in | input | 1 | Carry or borrow input for codes 1 and 3 |
| op_sel | input | 4 | Operation code |
| size_sel | input | 2 | Operand width select |
| flags_we | input | 1 | Commits next_flags into status |
| result | output | WORD_W | Width-masked result |
| write_back | output | 1 | Result should be stored |
| next_flags | output | 16 | Status word this operation produces |
| status | output | 16 | Registered status word |

## Verification
The bench builds the unit with its default WORD_W of 32, which is the only word width for which all three operand sizes exist side by side. At this width the 8-bit and 16-bit cases can be driven with nonzero upper operand bits, so it can be seen that those bits are ignored. The carry out of bit 31 comes from the extra adder bit, which makes the 0xFFFFFFFF+1 case reachable. Random operands at all four size codes are mixed with boundary values across the sign and carry edges at each width, with committed carries ahead of increments and with loops that decrement to zero.

// File: rtl/afu_pkg.sv
// Shared constants and types for the arithmetic status flag generator.
// Assumes a 16-bit status word with fixed flag positions.
package afu_pkg;
    localparam int STAT_W     = 16;
    localparam int CF_BIT     = 0;
    localparam int ONE_BIT    = 1;
    localparam int PF_BIT     = 2;
    localparam int AF_BIT     = 4;
    localparam int ZF_BIT     = 6;
    localparam int SF_BIT     = 7;
    localparam int OF_BIT     = 11;
    localparam int NUM_SIZES  = 3;
    localparam int MIN_LANE_W = 8;
    localparam int SIZE_SEL_W = 2;
    localparam int OP_W       = 4;
    localparam logic [STAT_W-1:0] STAT_RST = 16'h0002;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_CMP = 4'd4,
        OP_AND = 4'd5,
        OP_TST = 4'd6,
        OP_OR  = 4'd7,
        OP_XOR = 4'd8,
        OP_INC = 4'd9,
        OP_DEC = 4'd10
    } op_e;

    typedef enum logic [1:0] {
        CLS_NONE,
        CLS_ARITH,
        CLS_LOGIC,
        CLS_STEP
    } cls_e;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } flags_t;
endpackage

// File: rtl/afu_size_lane.sv
// Turns the size code into a width mask and a one-hot mark on the top bit
// of the selected width. Assumes WORD_W equals the widest lane (8 << 2).
// Size codes at or above NUM_SIZES map to the widest lane.
module afu_size_lane #(
    parameter int WORD_W = 32
) (
    input  logic [afu_pkg::SIZE_SEL_W-1:0] size_sel,
    output logic [WORD_W-1:0]              size_mask,
    output logic [WORD_W-1:0]              msb_onehot
);
    localparam int TAB_N = 1 << afu_pkg::SIZE_SEL_W;

    logic [WORD_W-1:0] mask_tab [TAB_N];
    logic [WORD_W-1:0] msb_tab  [TAB_N];

    // One table entry per size code; codes past the last lane reuse it.
    for (genvar g = 0; g < TAB_N; g++) begin : g_lane
        localparam int LANE_IDX = (g < afu_pkg::NUM_SIZES) ? g : afu_pkg::NUM_SIZES - 1;
        localparam int LANE_W   = afu_pkg::MIN_LANE_W << LANE_IDX;
        assign mask_tab[g] = {WORD_W{1'b1}} >> (WORD_W - LANE_W);
        assign msb_tab[g]  = {{(WORD_W-1){1'b0}}, 1'b1} << (LANE_W - 1);
    end

    // Pick the entry for the current size code.
    always_comb begin
        size_mask  = mask_tab[size_sel];
        msb_onehot = msb_tab[size_sel];
    end
endmodule

// File: rtl/afu_arith_core.sv
// Decodes the operation and computes the raw value on width-masked operands.
// Add and subtract share one adder that is one bit wider than the word, so
// the carry or borrow of any lane sits at the bit just above that lane.
module afu_arith_core #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0]          a_m,
    input  logic [WORD_W-1:0]          b_m,
    input  logic                       carry_in,
    input  logic [afu_pkg::OP_W-1:0]   op_sel,
    output afu_pkg::cls_e              cls,
    output logic                       is_sub,
    output logic [WORD_W-1:0]          b_eff,
    output logic [WORD_W:0]            raw,
    output logic [WORD_W-1:0]          value,
    output logic                       write_back
);
    import afu_pkg::*;

    localparam logic [WORD_W-1:0] ONE_W = {{(WORD_W-1){1'b0}}, 1'b1};

    op_e               op;
    logic              c_eff;
    logic [WORD_W:0]   c_ext;
    logic [WORD_W-1:0] logic_val;

    assign op    = op_e'(op_sel);
    assign c_ext = {{WORD_W{1'b0}}, c_eff};

    // Operation decode: class, adder direction, second operand, carry term.
    always_comb begin
        cls        = CLS_NONE;
        is_sub     = 1'b0;
        b_eff      = b_m;
        c_eff      = 1'b0;
        write_back = 1'b0;
        case (op)
            OP_ADD: begin cls = CLS_ARITH; write_back = 1'b1; end
            OP_ADC: begin cls = CLS_ARITH; c_eff = carry_in; write_back = 1'b1; end
            OP_SUB: begin cls = CLS_ARITH; is_sub = 1'b1; write_back = 1'b1; end
            OP_SBB: begin cls = CLS_ARITH; is_sub = 1'b1; c_eff = carry_in; write_back = 1'b1; end
            OP_CMP: begin cls = CLS_ARITH; is_sub = 1'b1; end
            OP_AND: begin cls = CLS_LOGIC; write_back = 1'b1; end
            OP_TST: begin cls = CLS_LOGIC; end
            OP_OR:  begin cls = CLS_LOGIC; write_back = 1'b1; end
            OP_XOR: begin cls = CLS_LOGIC; write_back = 1'b1; end
            OP_INC: begin cls = CLS_STEP; b_eff = ONE_W; write_back = 1'b1; end
            OP_DEC: begin cls = CLS_STEP; is_sub = 1'b1; b_eff = ONE_W; write_back = 1'b1; end
            default: begin cls = CLS_NONE; end
        endcase
    end

    // Shared adder/subtractor, one bit wider than the operands.
    assign raw = is_sub ? ({1'b0, a_m} - {1'b0, b_eff} - c_ext)
                        : ({1'b0, a_m} + {1'b0, b_eff} + c_ext);

    // Bitwise operations.
    always_comb begin
        case (op)
            OP_AND, OP_TST: logic_val = a_m & b_m;
            OP_OR:          logic_val = a_m | b_m;
            OP_XOR:         logic_val = a_m ^ b_m;
            default:        logic_val = '0;
        endcase
    end

    // Value selection by class; reserved codes give zero.
    always_comb begin
        case (cls)
            CLS_LOGIC:           value = logic_val;
            CLS_ARITH, CLS_STEP: value = raw[WORD_W-1:0];
            default:             value = '0;
        endcase
    end
endmodule

// File: rtl/afu_flag_pack.sv
// Derives the six flags from the adder output and the masked result, then
// packs them into the status word. Assumes a_m and result are already
// width-masked and msb_onehot marks the top bit of the selected width.
module afu_flag_pack #(
    parameter int WORD_W = 32
) (
    input  afu_pkg::cls_e                 cls,
    input  logic                          is_sub,
    input  logic [WORD_W-1:0]             a_m,
    input  logic [WORD_W-1:0]             b_eff,
    input  logic [WORD_W:0]               raw,
    input  logic [WORD_W-1:0]             result,
    input  logic [WORD_W-1:0]             msb_onehot,
    input  logic [afu_pkg::STAT_W-1:0]    prev_status,
    output logic [afu_pkg::STAT_W-1:0]    next_flags
);
    import afu_pkg::*;

    logic   lane_carry;
    logic   sign_a;
    logic   sign_b;
    logic   sign_r;
    logic   nib_carry;
    logic   ovf;
    flags_t fl;

    // Carry or borrow of the selected lane: the adder bit just above it.
    assign lane_carry = |(raw & {msb_onehot, 1'b0});
    assign sign_a     = |(a_m & msb_onehot);
    assign sign_b     = |(b_eff & msb_onehot);
    assign sign_r     = |(result & msb_onehot);
    assign nib_carry  = a_m[4] ^ b_eff[4] ^ raw[4];

    // Signed overflow from the operand and result signs.
    always_comb begin
        if (is_sub) ovf = (sign_a != sign_b) && (sign_r != sign_a);
        else        ovf = (sign_a == sign_b) && (sign_r != sign_a);
    end

    // Flag values per operation class.
    always_comb begin
        fl.pf = ~^result[7:0];
        fl.zf = ~|result;
        fl.sf = sign_r;
        case (cls)
            CLS_ARITH: begin fl.cf = lane_carry;          fl.af = nib_carry; fl.of = ovf;  end
            CLS_STEP:  begin fl.cf = prev_status[CF_BIT]; fl.af = nib_carry; fl.of = ovf;  end
            default:   begin fl.cf = 1'b0;                fl.af = 1'b0;      fl.of = 1'b0; end
        endcase
    end

    // Packing at fixed positions; reserved codes pass the status through.
    always_comb begin
        if (cls == CLS_NONE) begin
            next_flags = prev_status;
        end else begin
            next_flags          = '0;
            next_flags[ONE_BIT] = 1'b1;
            next_flags[CF_BIT]  = fl.cf;
            next_flags[PF_BIT]  = fl.pf;
            next_flags[AF_BIT]  = fl.af;
            next_flags[ZF_BIT]  = fl.zf;
            next_flags[SF_BIT]  = fl.sf;
            next_flags[OF_BIT]  = fl.of;
        end
    end
endmodule

// File: rtl/afu_status_reg.sv
// Holds the committed status word. Loads on a write enable and resets
// synchronously to the value with only the fixed bit set.
module afu_status_reg (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [afu_pkg::STAT_W-1:0] d,
    output logic [afu_pkg::STAT_W-1:0] q
);
    // Status storage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= afu_pkg::STAT_RST;
        else if (we) q <= d;
    end
endmodule

// File: rtl/arith_flag_unit.sv
// Top level of the arithmetic status flag generator. Masks the operands to
// the selected width, runs the shared core, forms the flag word and commits
// it into the status register when flags_we is high.
// Assumes WORD_W is 32 so that the 8, 16 and 32-bit lanes all exist.
module arith_flag_unit #(
    parameter int WORD_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [WORD_W-1:0]             op_a,
    input  logic [WORD_W-1:0]             op_b,
    input  logic                          carry_in,
    input  logic [afu_pkg::OP_W-1:0]      op_sel,
    input  logic [afu_pkg::SIZE_SEL_W-1:0] size_sel,
    input  logic                          flags_we,
    output logic [WORD_W-1:0]             result,
    output logic                          write_back,
    output logic [afu_pkg::STAT_W-1:0]    next_flags,
    output logic [afu_pkg::STAT_W-1:0]    status
);
    import afu_pkg::*;

    logic [WORD_W-1:0] size_mask;
    logic [WORD_W-1:0] msb_onehot;
    logic [WORD_W-1:0] a_m;
    logic [WORD_W-1:0] b_m;
    logic [WORD_W-1:0] b_eff;
    logic [WORD_W:0]   raw;
    logic [WORD_W-1:0] value;
    logic              is_sub;
    cls_e              cls;

    afu_size_lane #(.WORD_W(WORD_W)) u_lane (
        .size_sel   (size_sel),
        .size_mask  (size_mask),
        .msb_onehot (msb_onehot)
    );

    // Operand bits above the selected width are dropped here.
    assign a_m = op_a & size_mask;
    assign b_m = op_b & size_mask;

    afu_arith_core #(.WORD_W(WORD_W)) u_core (
        .a_m        (a_m),
        .b_m        (b_m),
        .carry_in   (carry_in),
        .op_sel     (op_sel),
        .cls        (cls),
        .is_sub     (is_sub),
        .b_eff      (b_eff),
        .raw        (raw),
        .value      (value),
        .write_back (write_back)
    );

    // Result bits above the selected width are cleared.
    assign result = value & size_mask;

    afu_flag_pack #(.WORD_W(WORD_W)) u_pack (
        .cls         (cls),
        .is_sub      (is_sub),
        .a_m         (a_m),
        .b_eff       (b_eff),
        .raw         (raw),
        .result      (result),
        .msb_onehot  (msb_onehot),
        .prev_status (status),
        .next_flags  (next_flags)
    );

    afu_status_reg u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (flags_we),
        .d     (next_flags),
        .q     (status)
    );
endmodule

// File: rtl/afu_checker.sv
// Temporal checks on the flag generator's ports, attached by bind.
module afu_checker #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_sel,
    input logic [1:0]        size_sel,
    input logic              flags_we,
    input logic [WORD_W-1:0] result,
    input logic              write_back,
    input logic [15:0]       next_flags,
    input logic [15:0]       status
);
    // R1
    fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] && ((status & 16'hF728) == 16'h0000));

    // R13
    hold_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_we |=> $stable(status));

    // R13
    commit_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |=> status == $past(next_flags));

    // R11
    logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel >= 4'd5 && op_sel <= 4'd8) |->
        (!next_flags[0] && !next_flags[4] && !next_flags[11]));

    // R12
    step_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd9 || op_sel == 4'd10) |-> next_flags[0] == status[0]);

    // R10
    no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd4 || op_sel == 4'd6) |-> !write_back);

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel <= 4'd10) |-> next_flags[6] == (result == '0));

    // R3
    byte_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size_sel == 2'd0) |-> result[WORD_W-1:8] == '0);

    // R14
    reserved_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > 4'd10) |-> (next_flags == status && result == '0));
endmodule

bind arith_flag_unit afu_checker #(.WORD_W(WORD_W)) u_afu_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_sel     (op_sel),
    .size_sel   (size_sel),
    .flags_we   (flags_we),
    .result     (result),
    .write_back (write_back),
    .next_flags (next_flags),
    .status     (status)
);

// File: tb/test_arith_flag_unit.sv
module test_arith_flag_unit;
    localparam int WORD_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [WORD_W-1:0] op_a = '0;
    logic [WORD_W-1:0] op_b = '0;
    logic              carry_in = 1'b0;
    logic [3:0]        op_sel = '0;
    logic [1:0]        size_sel = '0;
    logic              flags_we = 1'b0;
    logic [WORD_W-1:0] result;
    logic              write_back;
    logic [15:0]       next_flags;
    logic [15:0]       status;

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [15:0] exp_status = 16'h0002;

    always #10 clk = ~clk;

    arith_flag_unit #(.WORD_W(WORD_W)) i_arith_flag_unit (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
        .op_sel(op_sel), .size_sel(size_sel), .flags_we(flags_we), .result(result),
        .write_back(write_back), .next_flags(next_flags), .status(status)
    );

    // Reference model built from the requirements with wide signed arithmetic.
    function automatic void ref_model(input logic [31:0] a, input logic [31:0] b,
                                      input logic cin, input logic [3:0] op,
                                      input logic [1:0] sz, input logic [15:0] prev,
                                      output logic [31:0] res, output logic wb,
                                      output logic [15:0] fl);
        int     n;
        longint m, half, ua, ub, x, y, c, sx, sy, full, sr, r;
        logic   cf, af, of, sub, arith;
        n    = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        m    = (longint'(1) << n) - 1;
        half = longint'(1) << (n - 1);
        ua   = longint'(a) & m;
        ub   = longint'(b) & m;
        c    = cin ? 1 : 0;
        cf = 1'b0; af = 1'b0; of = 1'b0; sub = 1'b0; arith = 1'b1;
        x = ua; y = ub; r = 0;
        case (op)
            4'd0: c = 0;
            4'd1: ;
            4'd2, 4'd4: begin sub = 1'b1; c = 0; end
            4'd3: sub = 1'b1;
            4'd9: begin y = 1; c = 0; end
            4'd10: begin y = 1; c = 0; sub = 1'b1; end
            default: arith = 1'b0;
        endcase
        if (op > 4'd10) begin
            res = '0; wb = 1'b0; fl = prev;
            return;
        end
        if (arith) begin
            sx = (x >= half) ? x - (m + 1) : x;
            sy = (y >= half) ? y - (m + 1) : y;
            if (!sub) begin
                full = x + y + c;
                cf   = full > m;
                af   = ((x & 15) + (y & 15) + c) > 15;
                sr   = sx + sy + c;
            end else begin
                full = x - y - c;
                cf   = full < 0;
                af   = ((x & 15) - (y & 15) - c) < 0;
                sr   = sx - sy - c;
            end
            of = (sr > half - 1) || (sr < -half);
            r  = full & m;
            if (op == 4'd9 || op == 4'd10) cf = prev[0];
        end else begin
            case (op)
                4'd5, 4'd6: r = ua & ub;
                4'd7:       r = ua | ub;
                default:    r = ua ^ ub;
            endcase
        end
        res    = r[31:0];
        wb     = !(op == 4'd4 || op == 4'd6);
        fl     = 16'h0002;
        fl[0]  = cf;
        fl[2]  = ~^res[7:0];
        fl[4]  = af;
        fl[6]  = (res == 32'd0);
        fl[7]  = ((r >> (n - 1)) & 1) != 0;
        fl[11] = of;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One operation: check committed status, drive, check combinational outputs.
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic cin,
                          input logic [3:0] op, input logic [1:0] sz, input logic we);
        logic [31:0] er, msk;
        logic        ew;
        logic [15:0] ef;
        string       cf_tag;
        @(negedge clk);
        chk("R13 committed status", {16'h0, status}, {16'h0, exp_status});
        op_a = a; op_b = b; carry_in = cin; op_sel = op; size_sel = sz; flags_we = we;
        #2;
        ref_model(a, b, cin, op, sz, exp_status, er, ew, ef);
        msk = (sz == 2'd0) ? 32'h0000_00FF : (sz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
        chk("R2 result", result, er);
        chk("R3 bits above width", result & ~msk, 32'h0);
        chk("R10 write_back", {31'h0, write_back}, {31'h0, ew});
        if (op > 4'd10) begin
            chk("R14 reserved flags", {16'h0, next_flags}, {16'h0, ef});
        end else begin
            if (op >= 4'd5 && op <= 4'd8)       cf_tag = "R11 logic CF";
            else if (op == 4'd9 || op == 4'd10) cf_tag = "R12 step CF";
            else                                cf_tag = "R4 CF";
            chk(cf_tag, {31'h0, next_flags[0]}, {31'h0, ef[0]});
            chk("R5 PF", {31'h0, next_flags[2]}, {31'h0, ef[2]});
            chk("R6 AF", {31'h0, next_flags[4]}, {31'h0, ef[4]});
            chk("R7 ZF", {31'h0, next_flags[6]}, {31'h0, ef[6]});
            chk("R8 SF", {31'h0, next_flags[7]}, {31'h0, ef[7]});
            chk("R9 OF", {31'h0, next_flags[11]}, {31'h0, ef[11]});
            chk("R1 fixed bits", {16'h0, next_flags & 16'hF72A}, 32'h0000_0002);
        end
        if (we) exp_status = ef;
    endtask

    function automatic logic [31:0] pick();
        logic [31:0] v;
        if ($urandom % 4 == 0) begin
            case ($urandom % 10)
                0: v = 32'h0000_0000;
                1: v = 32'hFFFF_FFFF;
                2: v = 32'h0000_007F;
                3: v = 32'h0000_0080;
                4: v = 32'h0000_7FFF;
                5: v = 32'h0000_8000;
                6: v = 32'h7FFF_FFFF;
                7: v = 32'h8000_0000;
                8: v = 32'h0000_00FF;
                default: v = 32'h0000_FFFF;
            endcase
        end else begin
            v = $urandom;
        end
        return v;
    endfunction

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset value
        chk("R1 reset status", {16'h0, status}, 32'h0000_0002);
        rst_n = 1'b1;

        // R9 R8 R6: 0x7F+1 at byte width
        run_op(32'h7F, 32'h01, 1'b0, 4'd0, 2'd0, 1'b1);
        // R9 R6: 0x80-1 at byte width
        run_op(32'h80, 32'h01, 1'b0, 4'd2, 2'd0, 1'b1);
        // R4 R7: 0xFF+1 wraps to zero with carry
        run_op(32'hFF, 32'h01, 1'b0, 4'd0, 2'd0, 1'b1);
        // R12: increment keeps the committed carry
        run_op(32'h7F, 32'h00, 1'b0, 4'd9, 2'd0, 1'b1);
        // R3: upper operand bits ignored at byte width
        run_op(32'hABCD_12FF, 32'h55AA_0001, 1'b0, 4'd0, 2'd0, 1'b1);
        // 16-bit and 32-bit boundaries
        run_op(32'h7FFF, 32'h1, 1'b0, 4'd0, 2'd1, 1'b1);
        run_op(32'h8000, 32'h1, 1'b0, 4'd2, 2'd1, 1'b1);
        run_op(32'h7FFF_FFFF, 32'h1, 1'b0, 4'd0, 2'd2, 1'b1);
        run_op(32'hFFFF_FFFF, 32'h1, 1'b0, 4'd0, 2'd3, 1'b1);
        // R2: add and subtract with carry input
        run_op(32'hFF, 32'h00, 1'b1, 4'd1, 2'd0, 1'b1);
        run_op(32'h00, 32'h00, 1'b1, 4'd3, 2'd0, 1'b1);
        // R12: decrement keeps the borrow just committed
        run_op(32'h10, 32'h00, 1'b0, 4'd10, 2'd0, 1'b1);
        // R7: decrement loop down to zero
        for (int k = 3; k >= 1; k--) run_op(32'(k), 32'h0, 1'b0, 4'd10, 2'd1, 1'b1);
        // R10: compare and test
        run_op(32'h55, 32'h55, 1'b0, 4'd4, 2'd0, 1'b1);
        run_op(32'h8000_0000, 32'hC000_0000, 1'b0, 4'd6, 2'd2, 1'b1);
        // R13: flags not committed when the enable is low
        run_op(32'hFF, 32'h01, 1'b0, 4'd0, 2'd0, 1'b0);
        run_op(32'h01, 32'h01, 1'b0, 4'd7, 2'd0, 1'b0);
        // R14: reserved codes
        run_op(32'h1234, 32'h5678, 1'b1, 4'd11, 2'd1, 1'b1);
        run_op(32'hFFFF, 32'hFFFF, 1'b0, 4'd15, 2'd2, 1'b1);

        // Constrained random mix over all codes and sizes
        for (int i = 0; i < 1500; i++) begin
            run_op(pick(), pick(), 1'($urandom % 2), 4'($urandom % 12),
                   2'($urandom % 4), ($urandom % 4) != 0);
        end

        @(negedge clk);
        chk("R13 final status", {16'h0, status}, {16'h0, exp_status});
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog (R13 sequencing) actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule